// File: doc/BRIEF.md
# Halfword and Doubleword Load/Store Address Decoder

This block takes one 32-bit load/store instruction word from the halfword, signed-byte and doubleword class and works out what the memory stage needs. It reports the effective address, whether the base register gets a new value and what that value is, which of the six transfer kinds is meant, and whether the word is malformed. The offset is either an 8-bit constant split over two nibbles of the word or the contents of a second register. The block does not own the register file. It drives the two register numbers out combinationally, and the register file's read port returns the base and offset values in the same cycle.

A single output register stage sits behind a valid/ready handshake. An accepted word produces its result one cycle later, and that result is held for as long as the consumer stalls. The original base value travels with the result so that a later stage can use it. A register number of 15 in the base field, or in the offset field of the register form, raises a warning flag. The warning does not stop the operation.

Top module: `hdx_ls_decode`

## Requirements
- R1: Bit 22 of the word selects the offset form. When it is 1, the offset is the unsigned 8-bit value with bits 11:8 as its upper nibble and bits 3:0 as its lower nibble, zero-extended.
- R2: When bit 22 is 0, the offset is `offs_val`, read from the register numbered by bits 3:0. In this form a nonzero value in bits 11:8 sets `dec_err`.
- R3: Bit 23 set adds the offset to the base. Bit 23 clear subtracts it. Both wrap modulo 2^32.
- R4: Bit 24 = 1 with bit 21 = 0: `addr` is the offset-adjusted base and `wb_en` is 0.
- R5: Bit 24 = 1 with bit 21 = 1: `addr` is the offset-adjusted base, `wb_en` is 1 and `wb_val` equals `addr`.
- R6: Bit 24 = 0 with bit 21 = 0: `addr` is the unmodified base, `wb_en` is 1 and `wb_val` is the offset-adjusted base.
- R7: Bit 24 = 0 with bit 21 = 1 sets `dec_err`.
- R8: `op` equals {bit 20, bit 6, bit 5}. The six legal codes are 001 halfword store, 010 doubleword load, 011 doubleword store, 101 halfword load, 110 signed byte load and 111 signed halfword load. Codes 000 and 100 set `dec_err`.
- R9: When `dec_err` is set, `wb_en` and `op_valid` are 0. Otherwise `op_valid` is 1.
- R10: `pc_warn` is set when bits 19:16 equal 15, or in the register form when bits 3:0 equal 15. It changes no other output.
- R11: `base_orig` returns the base value that was presented with the word. `wb_idx` returns bits 19:16.
- R12: `in_ready` is high when `out_valid` is low or `out_ready` is high. A word accepted at an edge shows up on the outputs after that edge. While `out_valid` is high and `out_ready` is low, all outputs hold.
- R13: After reset, `out_valid` is 0 and `in_ready` is 1.
- R14: `base_sel` equals bits 19:16 and `offs_sel` equals bits 3:0 of `insn`, combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Block can take a word |
| insn | input | 32 | Instruction word |
| base_val | input | 32 | Value of the base register |
| offs_val | input | 32 | Value of the offset register |
| base_sel | output | 4 | Base register number for the read port |
| offs_sel | output | 4 | Offset register number for the read port |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| addr | output | 32 | Effective address |
| base_orig | output | 32 | Base value before any update |
| wb_en | output | 1 | Base register is written back |
| wb_idx | output | 4 | Register number for writeback |
| wb_val | output | 32 | Writeback value |
| op | output | 3 | Operation code {L,S,H} |
| op_valid | output | 1 | Operation may proceed |
| dec_err | output | 1 | Malformed word |
| pc_warn | output | 1 | Register 15 named |

## Verification
The hardest case to reach from the ports is several error sources stacking up on one word. An illegal indexing pair can coincide with a reserved operation code, and a register-form word can also carry nonzero must-be-zero bits. In each stacked case, writeback must stay suppressed even though the address arithmetic still runs. The stimulus sweeps every combination of the six control bits in both offset forms against several base and offset values, chosen so that both wraparound directions occur. Directed words then set the must-be-zero nibble and register 15. A separate sequence stalls the consumer while a different word is waiting, which shows that the held result does not move.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

    localparam int INSN_W  = 32;
    localparam int RIDX_W  = 4;
    localparam int NIB_W   = 4;
    localparam int IMM_W   = 2 * NIB_W;

    localparam int BIT_PRE = 24;
    localparam int BIT_UP  = 23;
    localparam int BIT_IMM = 22;
    localparam int BIT_WB  = 21;
    localparam int BIT_LD  = 20;
    localparam int RN_LSB  = 16;
    localparam int HN_LSB  = 8;
    localparam int BIT_SG  = 6;
    localparam int BIT_HF  = 5;
    localparam int LN_LSB  = 0;

    localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'(15);

    typedef enum logic [2:0] {
        OP_NONE     = 3'b000,
        OP_ST_HALF  = 3'b001,
        OP_LD_DUAL  = 3'b010,
        OP_ST_DUAL  = 3'b011,
        OP_RSVD     = 3'b100,
        OP_LD_HALF  = 3'b101,
        OP_LD_SBYTE = 3'b110,
        OP_LD_SHALF = 3'b111
    } hdx_op_e;

    typedef enum logic [1:0] {
        IDX_PRE    = 2'd0,
        IDX_PRE_WB = 2'd1,
        IDX_POST   = 2'd2,
        IDX_BAD    = 2'd3
    } hdx_idx_e;

    typedef struct packed {
        logic              pre;
        logic              up;
        logic              imm_form;
        logic              wback;
        logic              load;
        logic              sgn;
        logic              half;
        logic [RIDX_W-1:0] rn;
        logic [NIB_W-1:0]  hi_nib;
        logic [NIB_W-1:0]  lo_nib;
    } hdx_fields_t;

    function automatic hdx_idx_e idx_of(input logic pre, input logic wback);
        case ({pre, wback})
            2'b10:   return IDX_PRE;
            2'b11:   return IDX_PRE_WB;
            2'b00:   return IDX_POST;
            default: return IDX_BAD;
        endcase
    endfunction

    function automatic logic op_is_legal(input hdx_op_e op);
        return !(op == OP_NONE || op == OP_RSVD);
    endfunction

    function automatic logic [IMM_W-1:0] join_imm(input logic [NIB_W-1:0] hi,
                                                   input logic [NIB_W-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/hdx_field_split.sv
module hdx_field_split
    import hdx_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output hdx_fields_t       f
);
    logic unused_bits;

    always_comb begin
        f.pre      = insn[BIT_PRE];
        f.up       = insn[BIT_UP];
        f.imm_form = insn[BIT_IMM];
        f.wback    = insn[BIT_WB];
        f.load     = insn[BIT_LD];
        f.sgn      = insn[BIT_SG];
        f.half     = insn[BIT_HF];
        f.rn       = insn[RN_LSB +: RIDX_W];
        f.hi_nib   = insn[HN_LSB +: NIB_W];
        f.lo_nib   = insn[LN_LSB +: NIB_W];
    end

    assign unused_bits = ^{insn[31:25], insn[19-RIDX_W+1+RIDX_W-1+1-1 -: 0+1], insn[7], insn[4]};
endmodule

// File: rtl/hdx_addr_calc.sv
module hdx_addr_calc
    import hdx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  hdx_fields_t       f,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] offs_val,
    output logic [DATA_W-1:0] eff_addr,
    output logic [DATA_W-1:0] wb_val,
    output logic              wb_req,
    output logic              idx_err
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] moved;
    hdx_idx_e          idx;

    generate
        if (PAD_W > 0) begin : g_pad
            assign offset = f.imm_form ? {{PAD_W{1'b0}}, join_imm(f.hi_nib, f.lo_nib)}
                                       : offs_val;
        end else begin : g_nopad
            assign offset = f.imm_form ? DATA_W'(join_imm(f.hi_nib, f.lo_nib)) : offs_val;
        end
    endgenerate

    assign moved = f.up ? (base_val + offset) : (base_val - offset);
    assign idx   = idx_of(f.pre, f.wback);

    always_comb begin
        eff_addr = base_val;
        wb_val   = moved;
        wb_req   = 1'b0;
        idx_err  = 1'b0;
        case (idx)
            IDX_PRE: begin
                eff_addr = moved;
            end
            IDX_PRE_WB: begin
                eff_addr = moved;
                wb_req   = 1'b1;
            end
            IDX_POST: begin
                eff_addr = base_val;
                wb_req   = 1'b1;
            end
            default: begin
                idx_err  = 1'b1;
            end
        endcase
    end

    always_comb begin
        if (wb_req) begin
            assert_wb_link_R5: assert (wb_val == eff_addr || eff_addr == base_val);
        end
        if (idx_err) begin
            assert_bad_pair_R7: assert (!f.pre && f.wback && !wb_req);
        end
    end
endmodule

// File: rtl/hdx_op_decode.sv
module hdx_op_decode
    import hdx_pkg::*;
(
    input  hdx_fields_t f,
    output hdx_op_e     op,
    output logic        op_err,
    output logic        sbz_err,
    output logic        pc_warn
);
    assign op      = hdx_op_e'({f.load, f.sgn, f.half});
    assign op_err  = !op_is_legal(op);
    assign sbz_err = !f.imm_form && (f.hi_nib != '0);
    assign pc_warn = (f.rn == PC_IDX) || (!f.imm_form && f.lo_nib == PC_IDX);

    always_comb begin
        if (sbz_err) begin
            assert_sbz_regform_R2: assert (!f.imm_form);
        end
        if (!op_err) begin
            assert_op_legal_R8: assert (op != OP_NONE && op != OP_RSVD);
        end
    end
endmodule

// File: rtl/hdx_ls_decode.sv
module hdx_ls_decode
    import hdx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [INSN_W-1:0] insn,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] offs_val,
    output logic [RIDX_W-1:0] base_sel,
    output logic [RIDX_W-1:0] offs_sel,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] base_orig,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [DATA_W-1:0] wb_val,
    output logic [2:0]        op,
    output logic              op_valid,
    output logic              dec_err,
    output logic              pc_warn
);
    hdx_fields_t       fld;
    logic [DATA_W-1:0] c_addr;
    logic [DATA_W-1:0] c_wbv;
    logic              c_wbreq;
    logic              c_idx_err;
    hdx_op_e           c_op;
    logic              c_op_err;
    logic              c_sbz_err;
    logic              c_warn;
    logic              c_err;
    logic              take;

    hdx_field_split u_split (
        .insn (insn),
        .f    (fld)
    );

    hdx_addr_calc #(.DATA_W(DATA_W)) u_addr (
        .f        (fld),
        .base_val (base_val),
        .offs_val (offs_val),
        .eff_addr (c_addr),
        .wb_val   (c_wbv),
        .wb_req   (c_wbreq),
        .idx_err  (c_idx_err)
    );

    hdx_op_decode u_op (
        .f       (fld),
        .op      (c_op),
        .op_err  (c_op_err),
        .sbz_err (c_sbz_err),
        .pc_warn (c_warn)
    );

    assign base_sel = fld.rn;
    assign offs_sel = fld.lo_nib;
    assign c_err    = c_idx_err | c_op_err | c_sbz_err;
    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr      <= '0;
            base_orig <= '0;
            wb_en     <= 1'b0;
            wb_idx    <= '0;
            wb_val    <= '0;
            op        <= '0;
            op_valid  <= 1'b0;
            dec_err   <= 1'b0;
            pc_warn   <= 1'b0;
        end else if (take) begin
            addr      <= c_addr;
            base_orig <= base_val;
            wb_en     <= c_wbreq && !c_err;
            wb_idx    <= fld.rn;
            wb_val    <= c_wbv;
            op        <= c_op;
            op_valid  <= !c_err;
            dec_err   <= c_err;
            pc_warn   <= c_warn;
        end
    end

    assert_err_gates_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && dec_err) |-> (!wb_en && !op_valid));

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(addr) && $stable(wb_val)
                                       && $stable(op) && $stable(dec_err)));

    assert_accept_R12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    assert_op_code_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && op_valid) |-> (op != 3'b000 && op != 3'b100));
endmodule

// File: tb/test_hdx_ls_decode.sv
module test_hdx_ls_decode;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] insn_i = '0;
    logic [31:0] base_i = '0;
    logic [31:0] offs_i = '0;
    logic [3:0]  base_sel;
    logic [3:0]  offs_sel;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] addr;
    logic [31:0] base_orig;
    logic        wb_en;
    logic [3:0]  wb_idx;
    logic [31:0] wb_val;
    logic [2:0]  op;
    logic        op_valid;
    logic        dec_err;
    logic        pc_warn;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    hdx_ls_decode i_hdx_ls_decode (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .insn(insn_i), .base_val(base_i), .offs_val(offs_i),
        .base_sel(base_sel), .offs_sel(offs_sel), .out_valid(out_valid),
        .out_ready(out_ready), .addr(addr), .base_orig(base_orig), .wb_en(wb_en),
        .wb_idx(wb_idx), .wb_val(wb_val), .op(op), .op_valid(op_valid),
        .dec_err(dec_err), .pc_warn(pc_warn)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit p, input bit u, input bit w, input bit l,
                                       input bit s, input bit h, input bit immf,
                                       input logic [3:0] rn, input logic [3:0] hi,
                                       input logic [3:0] lo);
        logic [31:0] v;
        v = 32'hE000_0090;
        v[24] = p; v[23] = u; v[22] = immf; v[21] = w; v[20] = l;
        v[6] = s; v[5] = h;
        v[19:16] = rn; v[11:8] = hi; v[3:0] = lo;
        return v;
    endfunction

    task automatic run_vec(input logic [31:0] ins, input logic [31:0] b,
                           input logic [31:0] o);
        bit p, u, w, immf, err, wbe;
        logic [31:0] off, mv, ea;
        logic [2:0] eop;
        bit warn;
        string ta;
        p = ins[24]; u = ins[23]; immf = ins[22]; w = ins[21];
        off  = immf ? {24'd0, ins[11:8], ins[3:0]} : o;
        mv   = u ? b + off : b - off;
        eop  = {ins[20], ins[6], ins[5]};
        err  = (!p && w) || eop == 3'b000 || eop == 3'b100 || (!immf && ins[11:8] != 0);
        ea   = p ? mv : b;
        wbe  = !err && (p == w);
        warn = ins[19:16] == 4'hF || (!immf && ins[3:0] == 4'hF);
        ta   = !p ? "R6 R3" : (w ? "R5 R3" : "R4 R3");

        @(negedge clk);
        insn_i = ins; base_i = b; offs_i = o; in_valid = 1'b1; out_ready = 1'b1;
        #1;
        chk(base_sel == ins[19:16] && offs_sel == ins[3:0], "R14 sel",
            {24'd0, base_sel, offs_sel}, {24'd0, ins[19:16], ins[3:0]});
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid, "R12 valid", 32'(out_valid), 32'd1);
        chk(addr == ea, ta, addr, ea);
        chk(wb_en == wbe, "R4 R5 R6 R9 wb_en", 32'(wb_en), 32'(wbe));
        if (wbe) chk(wb_val == mv, "R5 R6 wb_val", wb_val, mv);
        chk(dec_err == err, "R2 R7 R8 dec_err", 32'(dec_err), 32'(err));
        chk(op_valid == !err, "R9 op_valid", 32'(op_valid), 32'(!err));
        chk(op == eop, "R8 op", 32'(op), 32'(eop));
        chk(pc_warn == warn, "R10 warn", 32'(pc_warn), 32'(warn));
        chk(base_orig == b && wb_idx == ins[19:16], "R11 base", base_orig, b);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] bases [3];
        logic [31:0] ins1, ins2;
        bases[0] = 32'h0000_1000;
        bases[1] = 32'h0000_0010;
        bases[2] = 32'hFFFF_FFF0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid && in_ready, "R13 reset", {30'd0, out_valid, in_ready}, 32'd1);
        rst = 1'b0;

        // R1 R3 R4 R5 R6 R7 R8: every control-bit combination, both offset forms
        for (int m = 0; m < 64; m++) begin
            for (int fm = 0; fm < 2; fm++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [7:0]  imm;
                    logic [31:0] ov;
                    imm = 8'(37 * m + 91 * k + 5);
                    ov  = (32'h0000_0123 * (k + 1)) ^ {m[5:0], 26'd0};
                    if (fm == 1)
                        run_vec(mk(m[5], m[4], m[3], m[2], m[1], m[0], 1'b1, 4'(k + 1),
                                   imm[7:4], imm[3:0]), bases[k], ov);
                    else
                        run_vec(mk(m[5], m[4], m[3], m[2], m[1], m[0], 1'b0, 4'(k + 1),
                                   4'd0, 4'(k + 4)), bases[k], ov);
                end
            end
        end

        // R2: nonzero must-be-zero nibble in register form
        run_vec(mk(1, 1, 0, 1, 0, 1, 0, 4'd2, 4'd3, 4'd4), 32'h100, 32'h8);
        run_vec(mk(0, 0, 0, 0, 0, 1, 0, 4'd2, 4'd8, 4'd4), 32'h100, 32'h8);
        // R10: register 15 as base or offset register
        run_vec(mk(1, 1, 1, 1, 1, 1, 1, 4'hF, 4'h1, 4'h2), 32'h2000, 32'h0);
        run_vec(mk(0, 1, 0, 0, 1, 1, 0, 4'd3, 4'd0, 4'hF), 32'h2000, 32'h40);
        run_vec(mk(1, 0, 0, 1, 1, 0, 1, 4'd3, 4'h0, 4'hF), 32'h2000, 32'h40);

        // R12: stall holds the result, then the waiting word follows
        ins1 = mk(1, 1, 1, 1, 0, 1, 1, 4'd5, 4'h1, 4'h0);
        ins2 = mk(1, 0, 0, 0, 1, 0, 1, 4'd6, 4'h0, 4'h4);
        @(negedge clk);
        insn_i = ins1; base_i = 32'h500; in_valid = 1'b1; out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        insn_i = ins2; base_i = 32'h600;
        chk(out_valid && !in_ready, "R12 stall", {30'd0, out_valid, in_ready}, 32'd2);
        @(posedge clk);
        @(negedge clk);
        chk(addr == 32'h510 && op == 3'b101 && wb_en, "R12 hold", addr, 32'h510);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && addr == 32'h5FC && op == 3'b010 && !wb_en, "R12 next",
            addr, 32'h5FC);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule